// File: doc/BRIEF.md
# Hint-Directed Data Cache

This block is a small set-associative data cache. It sits between a processor load/store port and a main-memory port. Every line holds a single data word, so a miss fetches exactly one word. Each request carries two hint bits, chosen per reference by the code generator. The bypass hint sends the access straight to memory without taking a line. The last-use hint declares that the value is dead after this access, so its line can be emptied at once. A dirty line that has been killed is dropped without a write-back.

Ordinary stores are write-back and write-allocate, using a dirty bit per line. Victim selection prefers an empty way. When every way of a set is valid, it uses a one-bit referenced stamp per line as a cheap stand-in for least-recently-used order. A build option takes the bypass hint from the top address bit instead of a pin. That bit is then cleared before the tag compare and before the memory address is formed. Both ports use a valid/ready handshake, and one request is in flight at a time.

Top module: `hint_cache`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the block is idle: cpu_ready is 1, cpu_rvalid is 0, mem_valid is 0, and every line is empty, so the first load of any address misses.
- R2: A load with cpu_bypass=0 and cpu_last=0 that misses issues one memory read (mem_write=0) of that word, places it in the cache and returns it. A repeat load that hits returns the word with no memory traffic.
- R3: A store with cpu_bypass=0 and cpu_last=0 writes the word into the cache and marks the line dirty. If it can take a clean or empty way, it does so with no memory traffic. A later load returns the stored word from the cache. No two ways of a set ever hold the same tag.
- R4: When an allocating access must evict a valid dirty line, the evicted word is first written to its own address in memory (mem_write=1), and only then is the new word fetched or placed.
- R5: A load with cpu_bypass=1 that hits returns the cached word and empties the line. If that line was dirty and cpu_last=0, the word is then written back to memory.
- R6: cpu_bypass=1 means "do not allocate" and 0 means "go through the cache". A bypassed load that misses reads memory directly and leaves the cache untouched.
- R7: A store with cpu_bypass=1 writes the word to memory and allocates nothing. If it hits, it also empties that line, so no stale copy survives.
- R8: An access with cpu_last=1 that hits empties the line and never writes it back, even when dirty. A last-use store with cpu_bypass=0 that hits leaves memory unchanged.
- R9: An access with cpu_last=1 that misses is served exactly as a bypassed access: a direct memory read or write, with no allocation.
- R10: An allocating miss picks the lowest-numbered empty way. If the set is full, it picks the lowest-numbered way whose stamp is clear, or way 0 if all stamps are set, and it clears every stamp of that set. Any access that leaves a line valid sets that line's stamp; emptying a line clears it.
- R11: cpu_ready is high only when idle, and each load ends with a single-cycle cpu_rvalid pulse in the cycle cpu_ready returns high. mem_valid, mem_write, mem_addr and mem_wdata are held stable until mem_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_bypass | input | 1 | Bypass hint, 1 = do not allocate (unused when taken from the address) |
| cpu_last | input | 1 | Last-use hint for the referenced value |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rvalid | output | 1 | Load data valid, one-cycle pulse |
| cpu_rdata | output | DATA_W | Load data |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts; read data valid in the same cycle |
| mem_write | output | 1 | 1 = memory write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A wrong valid, dirty or stamp bit stays invisible until its set is next touched. It then shows up as a memory read that should not happen, a read that is missing, or a write-back aimed at the wrong address. So the memory port is compared against the predicted operation list on every clock, and a fault shows within one transaction of the access that reveals it. A dropped or missing write-back from a last-use or bypass hit is only visible later, when a direct read returns the old or the new memory value. The directed sequences therefore read such addresses back through a bypass load. A randomized mix of all four hint combinations over a few tags per set then reaches states the directed cases miss.

// File: rtl/hc_pkg.sv
// Shared types for the hint-directed data cache.
// Assumes nothing beyond a single controller instance using the state type.
package hc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WB   = 2'd2,
        ST_MEM  = 2'd3
    } hc_state_e;
endpackage

// File: rtl/hc_line_store.sv
// Line storage: per set and way a valid, dirty and stamp bit, a tag and a
// one-word datum. The whole addressed set is read combinationally.
// Assumes one line write per cycle; a same-cycle stamp clear of the same set
// is applied first, so the written way's stamp still follows wr_valid.
module hc_line_store #(
    parameter int SETS   = 8,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int WAY_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_set,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0]              rd_dirty,
    output logic [WAYS-1:0]              rd_stamp,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic                         wr_valid,
    input  logic                         wr_dirty,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_set
);
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0]             dirty_q [SETS];
    logic [WAYS-1:0]             stamp_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];

    // Read port: present the whole addressed set.
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_dirty = dirty_q[rd_set];
        rd_stamp = stamp_q[rd_set];
        rd_tag   = tag_q[rd_set];
        rd_data  = data_q[rd_set];
    end

    // State bits: reset to empty, stamp clear then single-way update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                stamp_q[s] <= '0;
            end
        end else begin
            if (clr_en) stamp_q[clr_set] <= '0;
            if (wr_en) begin
                valid_q[wr_set][wr_way] <= wr_valid;
                dirty_q[wr_set][wr_way] <= wr_valid & wr_dirty;
                stamp_q[wr_set][wr_way] <= wr_valid;
            end
        end
    end

    // Tag and data payload: written only when a line becomes or stays valid.
    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            data_q[wr_set][wr_way] <= wr_data;
        end
    end

    // R8
    drop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !valid_q[$past(wr_set)][$past(wr_way)] &&
                                 !dirty_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/hc_victim_sel.sv
// Victim choice for one set: lowest empty way first; in a full set the
// lowest way with a clear stamp, else way 0. Purely combinational.
// Assumes the caller clears the set's stamps whenever full is reported.
module hc_victim_sel #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  stamp,
    output logic [WAY_W-1:0] way,
    output logic             full
);
    // Two priority scans: empty ways, then unstamped ways.
    always_comb begin
        logic got_empty;
        logic got_cold;
        logic [WAY_W-1:0] empty_w;
        logic [WAY_W-1:0] cold_w;
        got_empty = 1'b0;
        got_cold  = 1'b0;
        empty_w   = '0;
        cold_w    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!got_empty && !valid[w]) begin
                empty_w   = WAY_W'(w);
                got_empty = 1'b1;
            end
            if (!got_cold && !stamp[w]) begin
                cold_w   = WAY_W'(w);
                got_cold = 1'b1;
            end
        end
        full = &valid;
        way  = got_empty ? empty_w : (got_cold ? cold_w : '0);
    end
endmodule

// File: rtl/hint_cache.sv
// Hint-directed data cache controller with one-word lines.
// Accepts one load/store at a time, looks it up a cycle later against a
// registered copy of the request, then writes back and/or accesses memory
// as the bypass and last-use hints direct. Assumes memory returns read data
// in the cycle it raises mem_ready, and that SETS and WAYS are powers of two.
module hint_cache
    import hc_pkg::*;
#(
    parameter int ADDR_W          = 12,
    parameter int DATA_W          = 32,
    parameter int SETS            = 8,
    parameter int WAYS            = 2,
    parameter bit BYPASS_FROM_MSB = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_write,
    input  logic              cpu_bypass,
    input  logic              cpu_last,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    hc_state_e         st_q, st_d;
    logic              r_write, r_byp, r_last;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [IDX_W-1:0]  r_set;
    logic [TAG_W-1:0]  r_tag;
    logic              in_byp;
    logic [ADDR_W-1:0] in_addr;

    logic [WAYS-1:0]             rd_valid, rd_dirty, rd_stamp;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    logic [WAYS-1:0]             hit_vec;
    logic                        hit, hit_dirty;
    logic [WAY_W-1:0]            hit_way, vic_way;
    logic [DATA_W-1:0]           hit_data;
    logic                        vic_full, vic_valid, vic_dirty;

    logic              wr_en, wr_valid, wr_dirty, clr_en;
    logic [WAY_W-1:0]  wr_way;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    logic [WAY_W-1:0]  vway_q, vway_d;
    logic [ADDR_W-1:0] wb_addr_q, wb_addr_d;
    logic [DATA_W-1:0] wb_data_q, wb_data_d, resp_q, resp_d;
    logic              wb_then_q, wb_then_d;

    // Bypass hint source chosen at build time.
    generate
        if (BYPASS_FROM_MSB) begin : g_hint_msb
            assign in_byp  = cpu_addr[ADDR_W-1];
            assign in_addr = {1'b0, cpu_addr[ADDR_W-2:0]};
        end else begin : g_hint_pin
            assign in_byp  = cpu_bypass;
            assign in_addr = cpu_addr;
        end
    endgenerate

    assign r_set = r_addr[IDX_W-1:0];
    assign r_tag = r_addr[ADDR_W-1:IDX_W];

    hc_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .rd_set(r_set),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_stamp(rd_stamp),
        .rd_tag(rd_tag), .rd_data(rd_data),
        .wr_en(wr_en), .wr_set(r_set), .wr_way(wr_way), .wr_valid(wr_valid),
        .wr_dirty(wr_dirty), .wr_tag(wr_tag), .wr_data(wr_data),
        .clr_en(clr_en), .clr_set(r_set)
    );

    hc_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid(rd_valid), .stamp(rd_stamp), .way(vic_way), .full(vic_full)
    );

    // Per-way tag match.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_match
            assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == r_tag);
        end
    endgenerate

    // Encode the matching way and pick out its contents.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
        hit       = |hit_vec;
        hit_data  = rd_data[hit_way];
        hit_dirty = rd_dirty[hit_way];
        vic_valid = rd_valid[vic_way];
        vic_dirty = rd_dirty[vic_way];
    end

    // Next state, line writes and captured values per controller state.
    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        wr_way    = hit_way;
        wr_valid  = 1'b0;
        wr_dirty  = 1'b0;
        wr_tag    = r_tag;
        wr_data   = r_wdata;
        clr_en    = 1'b0;
        vway_d    = vway_q;
        wb_addr_d = wb_addr_q;
        wb_data_d = wb_data_q;
        wb_then_d = wb_then_q;
        resp_d    = resp_q;
        unique case (st_q)
            ST_IDLE: if (cpu_valid) st_d = ST_LOOK;
            ST_LOOK: begin
                if (hit) begin
                    wr_en = 1'b1;
                    if (!r_byp && !r_last) begin
                        wr_valid = 1'b1;
                        wr_dirty = r_write | hit_dirty;
                        wr_data  = r_write ? r_wdata : hit_data;
                        resp_d   = r_write ? resp_q : hit_data;
                        st_d     = ST_IDLE;
                    end else if (r_write) begin
                        st_d = r_byp ? ST_MEM : ST_IDLE;
                    end else begin
                        resp_d = hit_data;
                        if (r_byp && !r_last && hit_dirty) begin
                            wb_addr_d = r_addr;
                            wb_data_d = hit_data;
                            wb_then_d = 1'b0;
                            st_d      = ST_WB;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end
                end else if (r_byp || r_last) begin
                    st_d = ST_MEM;
                end else begin
                    vway_d = vic_way;
                    clr_en = vic_full;
                    if (vic_valid && vic_dirty) begin
                        wb_addr_d = {rd_tag[vic_way], r_set};
                        wb_data_d = rd_data[vic_way];
                        wb_then_d = 1'b1;
                        st_d      = ST_WB;
                    end else if (r_write) begin
                        wr_en    = 1'b1;
                        wr_way   = vic_way;
                        wr_valid = 1'b1;
                        wr_dirty = 1'b1;
                        st_d     = ST_IDLE;
                    end else begin
                        st_d = ST_MEM;
                    end
                end
            end
            ST_WB: if (mem_ready) begin
                if (!wb_then_q) begin
                    st_d = ST_IDLE;
                end else if (r_write) begin
                    wr_en    = 1'b1;
                    wr_way   = vway_q;
                    wr_valid = 1'b1;
                    wr_dirty = 1'b1;
                    st_d     = ST_IDLE;
                end else begin
                    st_d = ST_MEM;
                end
            end
            ST_MEM: if (mem_ready) begin
                if (!r_write) begin
                    resp_d = mem_rdata;
                    if (!r_byp && !r_last) begin
                        wr_en    = 1'b1;
                        wr_way   = vway_q;
                        wr_valid = 1'b1;
                        wr_data  = mem_rdata;
                    end
                end
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Controller state, load response and write-back holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cpu_rvalid <= 1'b0;
            resp_q     <= '0;
            vway_q     <= '0;
            wb_addr_q  <= '0;
            wb_data_q  <= '0;
            wb_then_q  <= 1'b0;
        end else begin
            st_q       <= st_d;
            cpu_rvalid <= (st_q != ST_IDLE) && (st_d == ST_IDLE) && !r_write;
            resp_q     <= resp_d;
            vway_q     <= vway_d;
            wb_addr_q  <= wb_addr_d;
            wb_data_q  <= wb_data_d;
            wb_then_q  <= wb_then_d;
        end
    end

    // Capture the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_byp   <= 1'b0;
            r_last  <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (st_q == ST_IDLE && cpu_valid) begin
            r_write <= cpu_write;
            r_byp   <= in_byp;
            r_last  <= cpu_last;
            r_addr  <= in_addr;
            r_wdata <= cpu_wdata;
        end
    end

    assign cpu_ready = (st_q == ST_IDLE);
    assign cpu_rdata = resp_q;
    assign mem_valid = (st_q == ST_WB) || (st_q == ST_MEM);
    assign mem_write = (st_q == ST_WB) || r_write;
    assign mem_addr  = (st_q == ST_WB) ? wb_addr_q : r_addr;
    assign mem_wdata = (st_q == ST_WB) ? wb_data_q : r_wdata;

    // R2
    load_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK && hit && !r_write && !r_byp && !r_last)
        |=> (!mem_valid && cpu_rvalid));
    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK) |-> $onehot0(hit_vec));
    // R10
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK && !hit && !vic_full) |-> !vic_valid);
    // R9
    direct_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK && !hit && (r_byp || r_last))
        |=> (mem_valid && mem_addr == $past(r_addr)));
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_write) && $stable(mem_wdata)));
    // R11
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);
endmodule

// File: tb/hint_cache_bench.sv
// Bench: a behavioural model predicts, per request, the list of memory
// operations and the load result; the memory port is compared every clock.
module hint_cache_bench;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NS = 8;
    localparam int NW = 2;

    typedef struct {
        bit          wr;
        int          addr;
        logic [31:0] data;
    } op_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0, cpu_bypass = 1'b0, cpu_last = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          mem_valid, mem_write;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R1";
    op_t expq[$];
    logic [31:0] mem_arr[int];
    logic [31:0] exp_mem[int];
    int hs_cnt = 0;
    int hs_done = 0;

    // Model state per set and way.
    bit          m_v[NS][NW];
    bit          m_d[NS][NW];
    bit          m_s[NS][NW];
    int          m_t[NS][NW];
    logic [31:0] m_x[NS][NW];

    hint_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .WAYS(NW)) u_hint_cache (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_write(cpu_write), .cpu_bypass(cpu_bypass), .cpu_last(cpu_last),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] init_val(int a);
        return (a * 32'h0001_0203) ^ 32'hA5C3_0000;
    endfunction

    function automatic logic [31:0] rd_exp(int a);
        return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_op(bit wr, int a, logic [31:0] d);
        op_t o;
        o.wr = wr; o.addr = a; o.data = d;
        expq.push_back(o);
        if (wr) exp_mem[a] = d;
    endtask

    // Reference behaviour of one request; returns the expected load data.
    task automatic model(bit we, bit byp, bit last, int a, logic [31:0] wd,
                         output logic [31:0] erd);
        int s, t, hw, vw;
        bit full, found;
        s = a % NS; t = a / NS; hw = -1; erd = '0;
        for (int w = 0; w < NW; w++) if (m_v[s][w] && m_t[s][w] == t) hw = w;
        if (hw >= 0) begin
            if (!byp && !last) begin
                if (we) begin m_x[s][hw] = wd; m_d[s][hw] = 1; end
                else erd = m_x[s][hw];
                m_s[s][hw] = 1;
            end else begin
                if (we) begin
                    if (byp) push_op(1, a, wd);
                end else begin
                    erd = m_x[s][hw];
                    if (byp && !last && m_d[s][hw]) push_op(1, a, m_x[s][hw]);
                end
                m_v[s][hw] = 0; m_d[s][hw] = 0; m_s[s][hw] = 0;
            end
        end else if (byp || last) begin
            if (we) push_op(1, a, wd);
            else begin push_op(0, a, '0); erd = rd_exp(a); end
        end else begin
            full = 1; found = 0; vw = 0;
            for (int w = 0; w < NW; w++) if (!m_v[s][w] && !found) begin vw = w; found = 1; end
            for (int w = 0; w < NW; w++) if (!m_v[s][w]) full = 0;
            if (full) begin
                found = 0;
                for (int w = 0; w < NW; w++) if (!m_s[s][w] && !found) begin vw = w; found = 1; end
                for (int w = 0; w < NW; w++) m_s[s][w] = 0;
            end
            if (m_v[s][vw] && m_d[s][vw]) push_op(1, m_t[s][vw] * NS + s, m_x[s][vw]);
            m_v[s][vw] = 1; m_s[s][vw] = 1; m_t[s][vw] = t;
            if (we) begin m_d[s][vw] = 1; m_x[s][vw] = wd; end
            else begin
                push_op(0, a, '0);
                m_d[s][vw] = 0; m_x[s][vw] = rd_exp(a); erd = m_x[s][vw];
            end
        end
    endtask

    // Issue one request and check its result once the block is idle again.
    task automatic access(string tag, bit we, bit byp, bit last, int a, logic [31:0] wd);
        logic [31:0] erd;
        bit saw_busy;
        cur_tag = tag;
        model(we, byp, last, a, wd, erd);
        @(negedge clk);
        cpu_valid = 1; cpu_write = we; cpu_bypass = byp; cpu_last = last;
        cpu_addr = AW'(a); cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 0;
        saw_busy = !cpu_ready;
        while (!cpu_ready) @(negedge clk);
        chk(saw_busy, "R11", "ready low after accept", 0, 1);
        chk(cpu_rvalid == !we, tag, "rvalid at completion", cpu_rvalid, !we);
        if (!we) chk(cpu_rdata == erd, tag, "load data", cpu_rdata, erd);
        chk(expq.size() == 0, tag, "memory ops outstanding", expq.size(), 0);
        expq.delete();
    endtask

    // Memory port monitor: every accepted operation against the prediction.
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            hs_cnt++;
            if (expq.size() == 0) begin
                chk(0, cur_tag, "unexpected memory op at addr", mem_addr, 0);
            end else begin
                op_t o;
                o = expq.pop_front();
                chk(mem_write == o.wr, cur_tag, "memory op kind", mem_write, o.wr);
                chk(int'(mem_addr) == o.addr, cur_tag, "memory address", mem_addr, o.addr);
                if (o.wr) chk(mem_wdata == o.data, cur_tag, "memory write data", mem_wdata, o.data);
            end
            if (mem_write) mem_arr[int'(mem_addr)] = mem_wdata;
        end
    end

    // Memory responder: two wait cycles, address hold checked while waiting.
    always @(negedge clk) begin
        static int wait_cnt = 0;
        static logic [AW-1:0] held_addr = '0;
        if (hs_done != hs_cnt || !mem_valid) begin
            hs_done = hs_cnt; wait_cnt = 0; mem_ready = 0;
        end else begin
            if (wait_cnt > 0)
                chk(mem_addr == held_addr, "R11", "memory address held", mem_addr, held_addr);
            held_addr = mem_addr;
            wait_cnt++;
            if (wait_cnt >= 3) begin
                mem_ready = 1;
                mem_rdata = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)]
                                                            : init_val(int'(mem_addr));
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, cur_tag, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_v[s][w] = 0; m_d[s][w] = 0; m_s[s][w] = 0; m_t[s][w] = 0; m_x[s][w] = '0;
            end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cpu_ready == 1, "R1", "ready after reset", cpu_ready, 1);
        chk(cpu_rvalid == 0, "R1", "rvalid after reset", cpu_rvalid, 0);
        chk(mem_valid == 0, "R1", "mem idle after reset", mem_valid, 0);
        // Set 0 holds addresses 0x000, 0x008, 0x010, ...
        access("R1", 0, 0, 0, 'h000, 0);          // first load misses
        access("R2", 0, 0, 0, 'h000, 0);          // hit, no traffic
        access("R3", 1, 0, 0, 'h008, 32'h1111_0008); // into empty way
        access("R3", 0, 0, 0, 'h008, 0);
        access("R10", 0, 0, 0, 'h010, 0);         // full, all stamped: way 0
        access("R4", 0, 0, 0, 'h018, 0);          // dirty cold way written back
        access("R6", 0, 1, 0, 'h008, 0);          // direct read, no allocation
        access("R6", 0, 0, 0, 'h008, 0);          // still a miss
        access("R3", 1, 0, 0, 'h018, 32'h2222_0018);
        access("R5", 0, 1, 0, 'h018, 0);          // hit, freed, written back
        access("R5", 0, 0, 0, 'h018, 0);          // miss shows it was freed
        access("R8", 1, 0, 0, 'h018, 32'h3333_0018);
        access("R8", 0, 0, 1, 'h018, 0);          // dirty line dropped
        access("R8", 0, 1, 0, 'h018, 0);          // memory still holds old word
        access("R9", 0, 0, 1, 'h020, 0);          // last-use miss: direct read
        access("R9", 1, 0, 1, 'h021, 32'h4444_0021);
        access("R7", 1, 1, 0, 'h008, 32'h5555_0008); // hit: memory write, line emptied
        access("R7", 0, 0, 0, 'h008, 0);
        access("R7", 1, 1, 0, 'h101, 32'h6666_0101);
        access("R8", 1, 0, 0, 'h003, 32'h7777_0003);
        access("R8", 1, 0, 1, 'h003, 32'h8888_0003); // last-use store hit: no write
        access("R8", 0, 1, 0, 'h003, 0);
        access("R5", 1, 0, 0, 'h005, 32'h9999_0005);
        access("R5", 0, 1, 1, 'h005, 0);          // bypass+last hit: no write-back
        access("R5", 0, 1, 0, 'h005, 0);
        for (int i = 0; i < 600; i++) begin
            int a;
            bit we, byp, last;
            a = int'($urandom % 40);
            we = $urandom % 2; byp = ($urandom % 4) == 0; last = ($urandom % 5) == 0;
            access("R10", we, byp, last, a, $urandom);
        end
        finish_run();
    end
endmodule